// File: doc/BRIEF.md
# Host Attention and Interrupt Signalling Bridge

This block carries signals in both directions between a simple host bus and an attached coprocessor. In the host-to-coprocessor direction, it watches host output cycles. When the low eight address bits equal a switch-selected port number, it raises a one-clock attention pulse toward the local CPU. The host data on that cycle plays no part, so the block has no host data input.

In the coprocessor-to-host direction, it produces one host interrupt request. That request comes from one of two sources. One is a software-controlled serial bit. The other is a set-only latch: any local read of a fixed register sets it, and a host interrupt acknowledge cycle clears it. The request goes to exactly one of ten active-low host lines, selected at reset: eight vectored lines, a non-maskable line and a general line.

During acknowledge cycles the block can also drive a programmable response byte onto the host data bus. The local CPU writes that byte through a memory-mapped register, and a configuration switch enables the drive.

Top module: `hostsig_bridge`

## Requirements
- R1: An output cycle is one with `host_out_stb` high and `host_addr` equal to `cfg_attn_port`. When such a cycle is first seen at a clock edge, `attn_pulse` is high for exactly the following clock cycle. The usual port number is F1 hex.
- R2: Holding the qualified strobe across further clock edges produces no further pulse. A new pulse needs the qualified strobe to go low and then high again.
- R3: An output strobe with a non-matching address never produces a pulse. Neither does a matching address without the strobe.
- R4: A local read (`loc_rd` high) at local address 8002 hex sets the interrupt latch at the next clock edge. Reads at other addresses and writes at 8002 hex leave the latch unchanged.
- R5: The latch clears at any clock edge where `host_ack` is high. When a set and an acknowledge fall on the same edge, the clear wins.
- R6: With `cfg_src_latch` = 0, the request follows `sw_irq_bit` and ignores the latch. With `cfg_src_latch` = 1, the request follows the latch and ignores `sw_irq_bit`.
- R7: The route code is 0 to 7 for vectored line `host_vi_n[code]`, 8 for `host_nmi_n` and 9 for `host_int_n`. Codes 10 to 15 drive no line. All lines are active low, and at most one line is low at any time.
- R8: The route code is taken from `cfg_route` only while reset is asserted. Changes to `cfg_route` after reset have no effect.
- R9: A local write (`loc_wr` high) at local address 8007 hex stores `loc_wdata` as the response byte. Writes to other addresses do not change it.
- R10: `host_data_oe` is high, and `host_data_out` carries the response byte, only while `host_ack` and `cfg_resp_en` are both high. At all other times `host_data_oe` is low and `host_data_out` is 00 hex.
- R11: After a synchronous reset (`rst_n` low at a clock edge), the latch and the response byte are zero. No host line is asserted while the latch source is selected, and `attn_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Low host address bits of an output cycle |
| host_out_stb | input | 1 | Host output strobe |
| host_ack | input | 1 | Host interrupt acknowledge cycle |
| host_data_out | output | 8 | Response byte toward the host data bus |
| host_data_oe | output | 1 | Output enable for the host data bus |
| host_vi_n | output | 8 | Vectored host interrupt lines, active low |
| host_nmi_n | output | 1 | Non-maskable host interrupt, active low |
| host_int_n | output | 1 | General host interrupt, active low |
| cfg_attn_port | input | 8 | Switch value for the attention port number |
| cfg_resp_en | input | 1 | Switch enabling the response byte drive |
| cfg_route | input | 4 | Host line route code, sampled during reset |
| cfg_src_latch | input | 1 | Request source: 0 serial bit, 1 latch |
| loc_addr | input | 16 | Local register bus address |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 8 | Local write data |
| sw_irq_bit | input | 1 | Software-controlled serial output bit |
| attn_pulse | output | 1 | One-clock attention pulse to the local CPU |

## Verification
The bench holds a matching strobe over several edges. A detector that works on level instead of edge would pulse again, or would stay high. It issues a set and an acknowledge on the same edge; a latch that gives set priority would keep the host line asserted. It changes the route input after reset and expects the original line to stay selected. It also walks the vectored, non-maskable, general and out-of-range codes, so a wrong decode shows up as the wrong line going low. Finally, it checks that a write to a neighbouring address leaves the response byte untouched, and that the bus is released whenever the enable switch or the acknowledge is absent.

// File: rtl/hostsig_pkg.sv
// Shared constants and types for the host attention and interrupt bridge.
// Assumes a 16-bit local register bus and an 8-bit host port space.
package hostsig_pkg;
    localparam int HADDR_W  = 8;
    localparam int DATA_W   = 8;
    localparam int LADDR_W  = 16;
    localparam int NUM_VEC  = 8;
    localparam int ROUTE_W  = 4;

    localparam logic [LADDR_W-1:0] LATCH_SET_ADDR    = 16'h8002;
    localparam logic [LADDR_W-1:0] RESP_REG_ADDR     = 16'h8007;
    localparam logic [HADDR_W-1:0] ATTN_PORT_DEFAULT = 8'hF1;

    typedef enum logic {
        SRC_SERIAL = 1'b0,
        SRC_LATCH  = 1'b1
    } irq_src_e;
endpackage

// File: rtl/attn_detect.sv
// Attention detector: qualifies host output strobes against the switch port
// number and emits a one-clock pulse on the rising edge of the qualified
// strobe. Assumes host inputs are already synchronous to clk.
module attn_detect #(
    parameter int HADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic               host_out_stb,
    input  logic [HADDR_W-1:0] cfg_attn_port,
    output logic               attn_pulse
);
    logic hit;
    logic hit_q;

    // Qualify the strobe with the port match.
    always_comb begin
        hit = host_out_stb && (host_addr == cfg_attn_port);
    end

    // Remember the last qualified level and form the edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q      <= 1'b0;
            attn_pulse <= 1'b0;
        end else begin
            hit_q      <= hit;
            attn_pulse <= hit && !hit_q;
        end
    end

    AST_ATTN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        attn_pulse |=> !attn_pulse); // R2
    AST_ATTN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_out_stb || host_addr != cfg_attn_port) |=> !attn_pulse); // R3
endmodule

// File: rtl/irq_latch.sv
// Host interrupt request source: a set-only latch set by a local read of a
// fixed register and cleared by host acknowledge, plus selection between the
// latch and the software serial bit. Clear has priority over set.
module irq_latch
    import hostsig_pkg::*;
#(
    parameter int                 LADDR_W  = 16,
    parameter logic [LADDR_W-1:0] SET_ADDR = 16'h8002
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] loc_addr,
    input  logic               loc_rd,
    input  logic               host_ack,
    input  logic               sw_irq_bit,
    input  irq_src_e           src_sel,
    output logic               irq_req
);
    logic set_hit;
    logic latch_q;

    // Decode the local read that sets the latch.
    always_comb begin
        set_hit = loc_rd && (loc_addr == SET_ADDR);
    end

    // Latch state: acknowledge clears, decoded read sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (host_ack) begin
            latch_q <= 1'b0;
        end else if (set_hit) begin
            latch_q <= 1'b1;
        end
    end

    // Pick the request source.
    always_comb begin
        irq_req = (src_sel == SRC_LATCH) ? latch_q : sw_irq_bit;
    end

    AST_LATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && !host_ack) |=> latch_q); // R4
    AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !latch_q); // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_hit && !host_ack) |=> $stable(latch_q)); // R4
endmodule

// File: rtl/irq_router.sv
// Routes the single interrupt request to one of the host lines. The route
// code is captured while reset is asserted and then held. Codes beyond the
// last line drive nothing. All outputs are active low.
module irq_router #(
    parameter int NUM_VEC = 8,
    parameter int ROUTE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ROUTE_W-1:0] cfg_route,
    input  logic               irq_req,
    output logic [NUM_VEC-1:0] host_vi_n,
    output logic               host_nmi_n,
    output logic               host_int_n
);
    localparam logic [ROUTE_W-1:0] CODE_NMI = ROUTE_W'(NUM_VEC);
    localparam logic [ROUTE_W-1:0] CODE_INT = ROUTE_W'(NUM_VEC + 1);

    logic [ROUTE_W-1:0] route_q;

    // Capture the route code during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= cfg_route;
        end
    end

    // One decoder per vectored line.
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
        assign host_vi_n[i] = !(irq_req && (route_q == ROUTE_W'(i)));
    end

    // Decode the two dedicated lines.
    always_comb begin
        host_nmi_n = !(irq_req && (route_q == CODE_NMI));
        host_int_n = !(irq_req && (route_q == CODE_INT));
    end

    AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(route_q)); // R8
endmodule

// File: rtl/resp_driver.sv
// Response byte register written from the local bus, and the host data bus
// driver that presents it during enabled acknowledge cycles only.
module resp_driver #(
    parameter int                 LADDR_W  = 16,
    parameter int                 DATA_W   = 8,
    parameter logic [LADDR_W-1:0] REG_ADDR = 16'h8007
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LADDR_W-1:0] loc_addr,
    input  logic               loc_wr,
    input  logic [DATA_W-1:0]  loc_wdata,
    input  logic               host_ack,
    input  logic               cfg_resp_en,
    output logic [DATA_W-1:0]  host_data_out,
    output logic               host_data_oe
);
    logic [DATA_W-1:0] resp_q;

    // Store the response byte on a decoded local write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (loc_wr && (loc_addr == REG_ADDR)) begin
            resp_q <= loc_wdata;
        end
    end

    // Drive the bus only during enabled acknowledge cycles.
    always_comb begin
        host_data_oe  = host_ack && cfg_resp_en;
        host_data_out = host_data_oe ? resp_q : '0;
    end

    AST_RESP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_wr && loc_addr == REG_ADDR) |=> $stable(resp_q)); // R9
endmodule

// File: rtl/hostsig_bridge.sv
// Top of the host attention and interrupt bridge. It ties together the
// attention detector, the interrupt request source, the line router and the
// response byte driver. Assumes all inputs are synchronous to clk.
module hostsig_bridge
    import hostsig_pkg::*;
#(
    parameter int HA_W = HADDR_W,
    parameter int D_W  = DATA_W,
    parameter int LA_W = LADDR_W,
    parameter int NV   = NUM_VEC,
    parameter int RT_W = ROUTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HA_W-1:0] host_addr,
    input  logic            host_out_stb,
    input  logic            host_ack,
    output logic [D_W-1:0]  host_data_out,
    output logic            host_data_oe,
    output logic [NV-1:0]   host_vi_n,
    output logic            host_nmi_n,
    output logic            host_int_n,
    input  logic [HA_W-1:0] cfg_attn_port,
    input  logic            cfg_resp_en,
    input  logic [RT_W-1:0] cfg_route,
    input  logic            cfg_src_latch,
    input  logic [LA_W-1:0] loc_addr,
    input  logic            loc_rd,
    input  logic            loc_wr,
    input  logic [D_W-1:0]  loc_wdata,
    input  logic            sw_irq_bit,
    output logic            attn_pulse
);
    logic     irq_req;
    irq_src_e src_sel;

    // Map the source switch onto the package type.
    always_comb begin
        src_sel = cfg_src_latch ? SRC_LATCH : SRC_SERIAL;
    end

    attn_detect #(.HADDR_W(HA_W)) i_attn (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_out_stb  (host_out_stb),
        .cfg_attn_port (cfg_attn_port),
        .attn_pulse    (attn_pulse)
    );

    irq_latch #(.LADDR_W(LA_W), .SET_ADDR(LA_W'(LATCH_SET_ADDR))) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_addr   (loc_addr),
        .loc_rd     (loc_rd),
        .host_ack   (host_ack),
        .sw_irq_bit (sw_irq_bit),
        .src_sel    (src_sel),
        .irq_req    (irq_req)
    );

    irq_router #(.NUM_VEC(NV), .ROUTE_W(RT_W)) i_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_route  (cfg_route),
        .irq_req    (irq_req),
        .host_vi_n  (host_vi_n),
        .host_nmi_n (host_nmi_n),
        .host_int_n (host_int_n)
    );

    resp_driver #(.LADDR_W(LA_W), .DATA_W(D_W), .REG_ADDR(LA_W'(RESP_REG_ADDR))) i_resp (
        .clk           (clk),
        .rst_n         (rst_n),
        .loc_addr      (loc_addr),
        .loc_wr        (loc_wr),
        .loc_wdata     (loc_wdata),
        .host_ack      (host_ack),
        .cfg_resp_en   (cfg_resp_en),
        .host_data_out (host_data_out),
        .host_data_oe  (host_data_oe)
    );

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{host_vi_n, host_nmi_n, host_int_n}) <= 1); // R7
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ack |-> (!host_data_oe && host_data_out == '0)); // R10
    AST_ACK_DROPS_LATCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && cfg_src_latch && $stable(cfg_src_latch)) |=>
        (cfg_src_latch != 1'b1 || $countones(~{host_vi_n, host_nmi_n, host_int_n}) == 0)); // R5
endmodule

// File: tb/test_hostsig_bridge.sv
module test_hostsig_bridge;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  host_addr;
    logic        host_out_stb;
    logic        host_ack;
    logic [7:0]  host_data_out;
    logic        host_data_oe;
    logic [7:0]  host_vi_n;
    logic        host_nmi_n;
    logic        host_int_n;
    logic [7:0]  cfg_attn_port;
    logic        cfg_resp_en;
    logic [3:0]  cfg_route;
    logic        cfg_src_latch;
    logic [15:0] loc_addr;
    logic        loc_rd;
    logic        loc_wr;
    logic [7:0]  loc_wdata;
    logic        sw_irq_bit;
    logic        attn_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostsig_bridge i_hostsig_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_out_stb(host_out_stb),
        .host_ack(host_ack), .host_data_out(host_data_out), .host_data_oe(host_data_oe),
        .host_vi_n(host_vi_n), .host_nmi_n(host_nmi_n), .host_int_n(host_int_n),
        .cfg_attn_port(cfg_attn_port), .cfg_resp_en(cfg_resp_en), .cfg_route(cfg_route),
        .cfg_src_latch(cfg_src_latch), .loc_addr(loc_addr), .loc_rd(loc_rd),
        .loc_wr(loc_wr), .loc_wdata(loc_wdata), .sw_irq_bit(sw_irq_bit),
        .attn_pulse(attn_pulse)
    );

    function automatic logic [9:0] lines();
        return {host_int_n, host_nmi_n, host_vi_n};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One posedge, then settle at the following negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(logic [3:0] route);
        @(negedge clk);
        rst_n = 1'b0; cfg_route = route;
        host_addr = '0; host_out_stb = 0; host_ack = 0;
        loc_addr = '0; loc_rd = 0; loc_wr = 0; loc_wdata = '0; sw_irq_bit = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        cfg_src_latch = 1; cfg_resp_en = 1; cfg_attn_port = 8'hF1;
        do_reset(4'd9);
        check("R11 attn", {15'd0, attn_pulse}, 16'd0);
        check("R11 lines", {6'd0, lines()}, 16'h03FF);
        check("R11 oe", {15'd0, host_data_oe}, 16'd0);
        host_ack = 1; #1;
        check("R11 resp zero", {8'd0, host_data_out}, 16'h0000);
        @(negedge clk); host_ack = 0;
    endtask

    task automatic t_attn();
        host_addr = 8'hF1; host_out_stb = 1;
        step();
        check("R1 pulse", {15'd0, attn_pulse}, 16'd1);
        step();
        check("R2 held no pulse", {15'd0, attn_pulse}, 16'd0);
        step();
        check("R2 still held", {15'd0, attn_pulse}, 16'd0);
        host_out_stb = 0; step();
        host_out_stb = 1; step();
        check("R2 retrigger", {15'd0, attn_pulse}, 16'd1);
        host_out_stb = 0; step();
        host_addr = 8'hF0; host_out_stb = 1; step();
        check("R3 wrong addr", {15'd0, attn_pulse}, 16'd0);
        host_out_stb = 0; host_addr = 8'hF1; step();
        check("R3 no strobe", {15'd0, attn_pulse}, 16'd0);
        cfg_attn_port = 8'h3C; host_addr = 8'h3C; host_out_stb = 1; step();
        check("R1 other port", {15'd0, attn_pulse}, 16'd1);
        host_out_stb = 0; cfg_attn_port = 8'hF1; step();
    endtask

    task automatic t_latch();
        loc_addr = 16'h8003; loc_rd = 1; step();
        loc_rd = 0;
        check("R4 other addr", {6'd0, lines()}, 16'h03FF);
        loc_addr = 16'h8002; loc_wr = 1; step();
        loc_wr = 0;
        check("R4 write ignored", {6'd0, lines()}, 16'h03FF);
        loc_rd = 1; step();
        loc_rd = 0;
        check("R4 set int", {6'd0, lines()}, 16'h01FF);
        step();
        check("R4 stays set", {6'd0, lines()}, 16'h01FF);
        host_ack = 1; step();
        host_ack = 0;
        check("R5 ack clears", {6'd0, lines()}, 16'h03FF);
        loc_rd = 1; host_ack = 1; step();
        loc_rd = 0; host_ack = 0;
        check("R5 clear wins", {6'd0, lines()}, 16'h03FF);
    endtask

    task automatic t_source();
        cfg_src_latch = 0; sw_irq_bit = 1; #1;
        check("R6 serial bit", {6'd0, lines()}, 16'h01FF);
        sw_irq_bit = 0; loc_addr = 16'h8002; loc_rd = 1; step();
        loc_rd = 0;
        check("R6 latch ignored", {6'd0, lines()}, 16'h03FF);
        cfg_src_latch = 1; #1;
        check("R6 latch selected", {6'd0, lines()}, 16'h01FF);
        sw_irq_bit = 1; cfg_src_latch = 1; host_ack = 1; step();
        host_ack = 0;
        check("R6 serial ignored", {6'd0, lines()}, 16'h03FF);
        sw_irq_bit = 0;
    endtask

    task automatic t_route();
        for (int code = 0; code < 12; code++) begin
            logic [9:0] exp;
            do_reset(code[3:0]);
            exp = 10'h3FF;
            if (code < 10) exp[code] = 1'b0;
            loc_addr = 16'h8002; loc_rd = 1; step();
            loc_rd = 0;
            check($sformatf("R7 code %0d", code), {6'd0, lines()}, {6'd0, exp});
        end
    endtask

    task automatic t_frozen();
        do_reset(4'd3);
        cfg_route = 4'd5;
        loc_addr = 16'h8002; loc_rd = 1; step();
        loc_rd = 0;
        check("R8 route held", {6'd0, lines()}, 16'h03F7);
        host_ack = 1; step(); host_ack = 0;
    endtask

    task automatic t_resp();
        loc_addr = 16'h8007; loc_wdata = 8'hA5; loc_wr = 1; step();
        loc_wr = 0;
        check("R10 idle oe", {15'd0, host_data_oe}, 16'd0);
        cfg_resp_en = 1; host_ack = 1; #1;
        check("R9 R10 drive", {7'd0, host_data_oe, host_data_out}, 16'h01A5);
        cfg_resp_en = 0; #1;
        check("R10 disabled", {7'd0, host_data_oe, host_data_out}, 16'h0000);
        @(negedge clk); host_ack = 0; cfg_resp_en = 1;
        loc_addr = 16'h8006; loc_wdata = 8'h3C; loc_wr = 1; step();
        loc_wr = 0; host_ack = 1; #1;
        check("R9 other addr", {7'd0, host_data_oe, host_data_out}, 16'h01A5);
        @(negedge clk); host_ack = 0;
    endtask

    initial begin
        rst_n = 1'b0;
        t_reset();
        t_attn();
        t_latch();
        t_source();
        t_route();
        t_frozen();
        t_resp();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 100000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule